// File: doc/BRIEF.md
# Second-Order Multibit Noise-Shaping Modulator

This block turns a stream of signed, already interpolated samples into a 6-bit noise-shaped level on every enabled clock. Two cascaded integrators form the loop filter. The quantized level is fed back into both of them, so the quantization error is pushed towards high frequencies with a second-order slope. The integrators saturate and never wrap. After an overload the loop recovers without help from outside the block.

The level then drives a bank of unit elements. The number of elements switched on always equals the level. A rotating pointer chooses which elements are on: each enabled cycle lights a run of consecutive elements, wrapping modulo the element count, that starts at the pointer. The pointer then moves on by the level. Every element is therefore used equally often, and element mismatch turns into shaped noise rather than distortion.

The clock enable paces the modulator at its sample rate. In the intended system this is 16 times the interpolator rate, for example 6.144 MHz against 384 kHz.

Top module: `sdm_mod`

## Requirements
- R1: A synchronous active-high reset clears both integrators, the rotation pointer, `code_o` and `elem_o`. After reset both outputs read zero.
- R2: While `en_i` is low, `code_o` and `elem_o` keep their values and no internal state advances, whatever `x_i` does.
- R3: `code_o` is a level from 0 to 2^CODE_W-1. The number of ones in `elem_o` always equals `code_o`.
- R4: The elements are numbered 0 to NUM_ELEM-1, with NUM_ELEM = 2^CODE_W-1. On each enabled cycle with level L and pointer P, bit k of `elem_o` is set exactly when (k-P) mod NUM_ELEM < L. The pointer then becomes (P+L) mod NUM_ELEM, and it starts at 0 after reset.
- R5: Level L stands for the feedback value (L-32)*2^(IN_W-CODE_W). Under a constant input x inside the stable range, the mean of `code_o` over a long run equals 32 + x/2^(IN_W-CODE_W).
- R6: The loop has a delay of two samples. From reset with a constant x, the first two levels are 32. The third level is clamp(floor((x + 2^(IN_W-CODE_W-1)) / 2^(IN_W-CODE_W)) + 32, 0, 63).
- R7: The integrators saturate and never wrap. An input beyond full scale pins the level at the nearest end for as long as the input is held there. When the input returns to zero, the mean level goes back to 32.
- R8: After reset, the number of enabled cycles in which each element has been on differs between any two elements by at most one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Sample enable, one modulator step per high cycle |
| x_i | input | IN_W | Signed two's-complement input sample |
| code_o | output | CODE_W | Registered quantized level |
| elem_o | output | NUM_ELEM | Registered unit-element select vector |

## Verification
A corrupted integrator shows up within about three enabled samples: the third level after reset is a closed-form function of the input. Over a few thousand samples the mean level then drifts away from the value the input predicts. A wrapped integrator shows up at once as a pinned level that jumps to the opposite end. A wrong rotation pointer breaks the exact expected element pattern on the very next enabled cycle, and over a long run it also breaks the even usage of the elements. A state that moves while the enable is low changes the outputs on the first enabled cycle after the hold.

// File: rtl/sdm_pkg.sv
package sdm_pkg;
  // Default sizes shared by the modulator modules.
  localparam int DEF_IN_W   = 16;
  localparam int DEF_CODE_W = 6;
  localparam int DEF_GUARD  = 4;  // extra integrator headroom bits

  // Number of unit elements driven by a level code of the given width.
  function automatic int elem_count(input int code_w);
    return (1 << code_w) - 1;
  endfunction
endpackage

// File: rtl/sdm_quant.sv
module sdm_quant #(
  parameter int CODE_W = 6,
  parameter int ACC_W  = 20,
  parameter int SHIFT  = 10
) (
  input  logic signed [ACC_W-1:0] acc_i,
  output logic        [CODE_W-1:0] level_o
);
  localparam int QW = ACC_W + 1;
  localparam logic signed [QW-1:0] HALF  = QW'(1 << (SHIFT - 1));
  localparam logic signed [QW-1:0] MID   = QW'(1 << (CODE_W - 1));
  localparam logic signed [QW-1:0] MAXL  = QW'((1 << CODE_W) - 1);
  localparam logic signed [QW-1:0] ZERO  = '0;

  logic signed [QW-1:0] rnd;
  logic signed [QW-1:0] q;
  logic signed [QW-1:0] lev_w;

  always_comb begin
    rnd   = $signed({acc_i[ACC_W-1], acc_i}) + HALF;
    q     = rnd >>> SHIFT;
    lev_w = q + MID;
    if (lev_w < ZERO)
      level_o = '0;
    else if (lev_w > MAXL)
      level_o = MAXL[CODE_W-1:0];
    else
      level_o = lev_w[CODE_W-1:0];
  end
endmodule

// File: rtl/sdm_loop.sv
module sdm_loop #(
  parameter int IN_W   = 16,
  parameter int CODE_W = 6,
  parameter int ACC_W  = 20
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en_i,
  input  logic signed [IN_W-1:0]  x_i,
  input  logic        [CODE_W-1:0] level_i,
  output logic signed [ACC_W-1:0] i2_o
);
  localparam int SHIFT = IN_W - CODE_W;
  localparam int EXT_W = ACC_W + 2;
  localparam logic signed [ACC_W-1:0] MID_A = ACC_W'(1 << (CODE_W - 1));
  localparam logic signed [EXT_W-1:0] SAT_HI =
    $signed({{(EXT_W-ACC_W+1){1'b0}}, {(ACC_W-1){1'b1}}});
  localparam logic signed [EXT_W-1:0] SAT_LO =
    $signed({{(EXT_W-ACC_W+1){1'b1}}, {(ACC_W-1){1'b0}}});

  logic signed [ACC_W-1:0] i1_q, i2_q;
  logic signed [ACC_W-1:0] lev_s, fb;
  logic signed [EXT_W-1:0] x_e, i1_e, i2_e, fb_e, s1, s2;
  logic signed [ACC_W-1:0] i1_d, i2_d;

  always_comb begin
    lev_s = $signed({{(ACC_W-CODE_W){1'b0}}, level_i}) - MID_A;
    fb    = lev_s <<< SHIFT;
    x_e   = $signed({{(EXT_W-IN_W){x_i[IN_W-1]}}, x_i});
    i1_e  = $signed({{(EXT_W-ACC_W){i1_q[ACC_W-1]}}, i1_q});
    i2_e  = $signed({{(EXT_W-ACC_W){i2_q[ACC_W-1]}}, i2_q});
    fb_e  = $signed({{(EXT_W-ACC_W){fb[ACC_W-1]}}, fb});
    s1    = i1_e + x_e - fb_e;
    s2    = i2_e + i1_e - (fb_e <<< 1);
    if (s1 > SAT_HI)      i1_d = SAT_HI[ACC_W-1:0];
    else if (s1 < SAT_LO) i1_d = SAT_LO[ACC_W-1:0];
    else                  i1_d = s1[ACC_W-1:0];
    if (s2 > SAT_HI)      i2_d = SAT_HI[ACC_W-1:0];
    else if (s2 < SAT_LO) i2_d = SAT_LO[ACC_W-1:0];
    else                  i2_d = s2[ACC_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      i1_q <= '0;
      i2_q <= '0;
    end else if (en_i) begin
      i1_q <= i1_d;
      i2_q <= i2_d;
    end
  end

  assign i2_o = i2_q;

  // R7: adding a non-negative amount must never make the first integrator smaller
  a_r7_no_wrap: assert property (@(posedge clk) disable iff (rst)
    (en_i && x_i >= 0 && fb <= 0) |=> (i1_q >= $past(i1_q)));

  // R7: the mirror case for a non-positive amount
  a_r7_no_wrap_neg: assert property (@(posedge clk) disable iff (rst)
    (en_i && x_i <= 0 && fb >= 0) |=> (i1_q <= $past(i1_q)));

  // R2: the integrators are frozen while the enable is low
  a_r2_loop_hold: assert property (@(posedge clk) disable iff (rst)
    (!en_i) |=> ($stable(i1_q) && $stable(i2_q)));
endmodule

// File: rtl/sdm_dwa.sv
module sdm_dwa #(
  parameter int CODE_W   = 6,
  parameter int NUM_ELEM = 63
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en_i,
  input  logic [CODE_W-1:0]   level_i,
  output logic [NUM_ELEM-1:0] elem_o
);
  localparam int PTR_W = $clog2(NUM_ELEM);
  localparam int SUM_W = ((PTR_W > CODE_W) ? PTR_W : CODE_W) + 1;
  localparam logic [SUM_W-1:0] N_S = SUM_W'(NUM_ELEM);

  logic [PTR_W-1:0]    ptr_q;
  logic [SUM_W-1:0]    ptr_s, lev_s, ptr_sum, ptr_nxt;
  logic [NUM_ELEM-1:0] sel_d;
  logic [NUM_ELEM-1:0] elem_q;

  always_comb begin
    ptr_s   = SUM_W'(ptr_q);
    lev_s   = SUM_W'(level_i);
    ptr_sum = ptr_s + lev_s;
    ptr_nxt = (ptr_sum >= N_S) ? (ptr_sum - N_S) : ptr_sum;
  end

  for (genvar k = 0; k < NUM_ELEM; k++) begin : g_elem
    localparam logic [SUM_W-1:0] K_S = SUM_W'(k);
    logic [SUM_W-1:0] off;
    always_comb begin
      off = (K_S >= ptr_s) ? (K_S - ptr_s) : (K_S + N_S - ptr_s);
      sel_d[k] = (off < lev_s);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q  <= '0;
      elem_q <= '0;
    end else if (en_i) begin
      ptr_q  <= ptr_nxt[PTR_W-1:0];
      elem_q <= sel_d;
    end
  end

  assign elem_o = elem_q;

  // R4: the pointer always names a real element
  a_r4_ptr_range: assert property (@(posedge clk) disable iff (rst)
    32'(ptr_q) < NUM_ELEM);

  // R4: a non-empty run begins at the element the pointer named
  a_r4_run_start: assert property (@(posedge clk) disable iff (rst)
    (en_i && level_i != '0) |=> elem_o[$past(ptr_q)]);
endmodule

// File: rtl/sdm_mod.sv
module sdm_mod
  import sdm_pkg::*;
#(
  parameter int IN_W   = DEF_IN_W,
  parameter int CODE_W = DEF_CODE_W,
  localparam int NUM_ELEM = elem_count(CODE_W)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     en_i,
  input  logic signed [IN_W-1:0]   x_i,
  output logic        [CODE_W-1:0] code_o,
  output logic        [NUM_ELEM-1:0] elem_o
);
  localparam int ACC_W = IN_W + DEF_GUARD;
  localparam int SHIFT = IN_W - CODE_W;

  logic signed [ACC_W-1:0] i2;
  logic [CODE_W-1:0]       level;
  logic [CODE_W-1:0]       code_q;

  sdm_loop #(.IN_W(IN_W), .CODE_W(CODE_W), .ACC_W(ACC_W)) u_loop (
    .clk(clk), .rst(rst), .en_i(en_i), .x_i(x_i),
    .level_i(level), .i2_o(i2)
  );

  sdm_quant #(.CODE_W(CODE_W), .ACC_W(ACC_W), .SHIFT(SHIFT)) u_quant (
    .acc_i(i2), .level_o(level)
  );

  sdm_dwa #(.CODE_W(CODE_W), .NUM_ELEM(NUM_ELEM)) u_dwa (
    .clk(clk), .rst(rst), .en_i(en_i), .level_i(level), .elem_o(elem_o)
  );

  always_ff @(posedge clk) begin
    if (rst)       code_q <= '0;
    else if (en_i) code_q <= level;
  end

  assign code_o = code_q;

  // R1: both outputs read zero after a reset cycle
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (code_o == '0 && elem_o == '0));

  // R3: the element count matches the level
  a_r3_pop_eq_code: assert property (@(posedge clk) disable iff (rst)
    $countones(elem_o) == 32'(code_o));

  // R2: the outputs hold while the enable is low
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    (!en_i) |=> ($stable(code_o) && $stable(elem_o)));
endmodule

// File: tb/sdm_mod_tb_top.sv
`timescale 1ns/1ps
module sdm_mod_tb_top;
  localparam int IN_W   = 16;
  localparam int CODE_W = 6;
  localparam int N      = 63;
  localparam int STEP   = 1 << (IN_W - CODE_W);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en_i = 1'b0;
  logic signed [IN_W-1:0] x_i = '0;
  logic [CODE_W-1:0] code_o;
  logic [N-1:0] elem_o;

  int n_checks = 0;
  int n_fail = 0;
  int ptr_m = 0;
  int use_cnt [N];
  bit done = 1'b0;

  always #5 clk = ~clk;

  sdm_mod #(.IN_W(IN_W), .CODE_W(CODE_W)) dut_i (
    .clk(clk), .rst(rst), .en_i(en_i), .x_i(x_i),
    .code_o(code_o), .elem_o(elem_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; en_i = 1'b0; x_i = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(code_o == '0, "R1", "code after reset", longint'(code_o), 0);
    chk(elem_o == '0, "R1", "elements after reset", longint'(elem_o), 0);
    ptr_m = 0;
    for (int k = 0; k < N; k++) use_cnt[k] = 0;
  endtask

  // One enabled sample; checks the element pattern against the rotation model.
  task automatic tick(input logic signed [IN_W-1:0] x);
    logic [N-1:0] exp_e;
    int lv;
    @(negedge clk);
    en_i = 1'b1; x_i = x;
    @(posedge clk);
    #1;
    lv = int'(code_o);
    for (int k = 0; k < N; k++) exp_e[k] = (((k - ptr_m + N) % N) < lv);
    chk($countones(elem_o) == lv, "R3", "popcount vs code",
        longint'($countones(elem_o)), longint'(lv));
    chk(elem_o == exp_e, "R4", "element pattern", longint'(elem_o), longint'(exp_e));
    for (int k = 0; k < N; k++) if (exp_e[k]) use_cnt[k]++;
    ptr_m = (ptr_m + lv) % N;
  endtask

  task automatic check_usage();
    int mn, mx;
    mn = use_cnt[0]; mx = use_cnt[0];
    for (int k = 1; k < N; k++) begin
      if (use_cnt[k] < mn) mn = use_cnt[k];
      if (use_cnt[k] > mx) mx = use_cnt[k];
    end
    chk((mx - mn) <= 1, "R8", "usage spread", longint'(mx - mn), 1);
  endtask

  function automatic int first_level(input int x);
    int q;
    q = ((x + STEP / 2) >>> (IN_W - CODE_W)) + 32;
    if (q < 0) q = 0;
    if (q > 63) q = 63;
    return q;
  endfunction

  task automatic start_codes(input int x);
    do_reset();
    tick(IN_W'(x));
    chk(code_o == 6'd32, "R6", "first level", longint'(code_o), 32);
    tick(IN_W'(x));
    chk(code_o == 6'd32, "R6", "second level", longint'(code_o), 32);
    tick(IN_W'(x));
    chk(int'(code_o) == first_level(x), "R6", "third level",
        longint'(code_o), longint'(first_level(x)));
  endtask

  task automatic run_dc(input int x, input int n);
    real mean, expm, d;
    longint sum;
    do_reset();
    repeat (64) tick(IN_W'(x));
    sum = 0;
    for (int i = 0; i < n; i++) begin
      tick(IN_W'(x));
      sum += longint'(code_o);
    end
    mean = real'(sum) / real'(n);
    expm = 32.0 + real'(x) / real'(STEP);
    d = mean - expm;
    if (d < 0.0) d = -d;
    chk(d < 0.02, "R5", "mean level x1000",
        longint'(mean * 1000.0), longint'(expm * 1000.0));
    check_usage();
  endtask

  task automatic hold_test();
    logic [CODE_W-1:0] c0;
    logic [N-1:0] e0;
    do_reset();
    repeat (20) tick(IN_W'(7000));
    c0 = code_o; e0 = elem_o;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      en_i = 1'b0; x_i = IN_W'(i * 9000 - 20000);
      @(posedge clk);
      #1;
      chk(code_o == c0, "R2", "code held", longint'(code_o), longint'(c0));
      chk(elem_o == e0, "R2", "elements held", longint'(elem_o), longint'(e0));
    end
    // the rotation model continues from where it stopped (R2, R4)
    repeat (40) tick(IN_W'(7000));
  endtask

  task automatic overload_test();
    int bad_hi;
    int bad_lo;
    real mean, d;
    longint sum;
    do_reset();
    bad_hi = 0;
    for (int i = 0; i < 2000; i++) begin
      tick(IN_W'(32767));
      if (i >= 2 && code_o != 6'd63) bad_hi++;
    end
    chk(bad_hi == 0, "R7", "cycles not pinned high", longint'(bad_hi), 0);
    repeat (3000) tick('0);
    sum = 0;
    for (int i = 0; i < 1024; i++) begin
      tick('0);
      sum += longint'(code_o);
    end
    mean = real'(sum) / 1024.0;
    d = mean - 32.0;
    if (d < 0.0) d = -d;
    chk(d < 0.1, "R7", "recovered mean x1000", longint'(mean * 1000.0), 32000);
    bad_lo = 0;
    for (int i = 0; i < 2000; i++) begin
      tick(IN_W'(-32768));
      if (i >= 40 && code_o != 6'd0) bad_lo++;
    end
    chk(bad_lo == 0, "R7", "cycles not pinned low", longint'(bad_lo), 0);
    check_usage();
  endtask

  initial begin
    for (int k = 0; k < N; k++) use_cnt[k] = 0;
    repeat (3) @(posedge clk);
    do_reset();
    start_codes(0);
    start_codes(5000);
    start_codes(-5000);
    start_codes(31000);
    start_codes(-32768);
    start_codes(32767);
    hold_test();
    run_dc(0, 4096);
    run_dc(-20 * STEP, 4096);
    run_dc(-7 * STEP + 300, 4096);
    run_dc(5 * STEP + 123, 4096);
    run_dc(25 * STEP, 4096);
    overload_test();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    #1500000;
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule